// File: doc/BRIEF.md
# Triple Parallel Port with Carrier Modulation

This block holds the output state of three 8-bit general-purpose ports for a small microcontroller. A special-function-register bus reaches it. Each pin has an output latch and a weak pull-up enable. For every pin the block produces an output-enable and an output-value pair, together with a pull-up request, so that a pad can be modelled either as a quasi-bidirectional pin with a weak pull-up or as an open-drain pin.

A CPU read returns one of two values, chosen by a read-mode input. The first is the latch contents, which read-modify-write sequences need. The second is the level actually present on the pins, taken through a two-flop synchronizer. A single-bit write path updates one latch bit and leaves the other bits of that port as they were.

The block also has a divider that turns the system clock into a square-wave carrier at about 38 kHz. A configuration register picks which of eight pins, all on one port, carry that carrier XORed with their latch level. A global enable input switches modulation on and off. This suits infrared transmit or low-power LED drive.

Top module: `port_carrier_io`

## Requirements
- R1: After reset, every port latch reads 0xFF, every pull-up register reads 0x00 (all weak pull-ups on) and the modulation select register reads 0x00.
- R2: A byte write to 0x80, 0x90 or 0xA0 loads port 0, 1 or 2. A read of that address with `rd_pin`=0 returns the latch value in the same cycle.
- R3: A bit write with `bit_addr[7:3]` equal to 0x10, 0x12 or 0x14 (ports 0, 1, 2) and bit index `bit_addr[2:0]` sets that one latch bit to `bit_val` and leaves the other seven bits unchanged. If a byte write to the same port happens in the same cycle, the byte write wins.
- R4: A port read with `rd_pin`=1 returns `pin_in` after a two-flop synchronizer. A change applied before clock edge k is first visible after edge k+1, and the read is independent of the latch.
- R5: Pull-up registers for ports 0, 1 and 2 sit at 0xB2, 0xB3 and 0xB4, and the modulation select register sits at 0x9F. Each reads back what was last written. A pull-up bit of 0 means the pull-up is enabled.
- R6: A pin with its pull-up enabled gives `pin_pu`=1, `pin_oe`=1 and `pin_out` equal to its drive level. A pin with its pull-up disabled is open-drain: `pin_pu`=0, `pin_out`=0, and `pin_oe`=1 only when the drive level is 0.
- R7: When `mod_en`=1 and select bit k is 1, the drive level of pin k on port `MOD_PORT` (default 1, pins 8..15) equals latch XOR carrier. Reading the latch still returns the unmodulated value.
- R8: The carrier starts low after reset and toggles every HALF = round(CLK_HZ / (2*CARRIER_HZ)) clocks, which is 1645 at the defaults, so it has a 50% duty cycle.
- R9: With `mod_en`=0, or with a select bit of 0, or on a port other than `MOD_PORT`, a pin's drive level equals its latch bit.
- R10: Byte writes to addresses outside the seven registers, and bit writes outside the three port ranges, change no register. Reads of unmapped addresses, and any read with `sfr_rd`=0, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register address for byte access |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rd | input | 1 | Read strobe |
| rd_pin | input | 1 | Read mode for port registers: 1 = pin level, 0 = latch |
| sfr_rdata | output | 8 | Read data (combinational) |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address: register block in [7:3], bit index in [2:0] |
| bit_val | input | 1 | Value for the single-bit write |
| mod_en | input | 1 | Global carrier modulation enable |
| pin_in | input | 24 | Pin levels, port p bit i at index 8p+i |
| pin_oe | output | 24 | Pad output enable per pin |
| pin_out | output | 24 | Pad output value per pin |
| pin_pu | output | 24 | Weak pull-up request per pin |

## Verification
On every cycle the bound checker confirms several things. An open-drain pin never drives high, and a pulled-up pin always drives. Pins outside the modulated set follow their latch. Byte and bit writes land in the next cycle. The carrier's toggle spacing is exactly HALF. Unmapped reads return zero. Some properties only the bench's scenarios can show: that the latch and pin read paths diverge when an external agent pulls a latched-1 pin low, that the synchronizer's latency is two edges, that a modulated pin's measured period and duty cycle are correct, that two selected pins with opposite latches run in antiphase, and that unselected or disabled pins stay steady.

// File: rtl/pcio_pkg.sv
package pcio_pkg;
   localparam int NPORTS   = 3;
   localparam int PW       = 8;
   localparam logic [7:0] CFG_ADDR = 8'h9F;

   function automatic logic [7:0] port_addr(input int p);
      return 8'h80 + 8'(p * 16);
   endfunction

   function automatic logic [7:0] pu_addr(input int p);
      return 8'hB2 + 8'(p);
   endfunction

   function automatic logic [4:0] port_bitblk(input int p);
      return 5'h10 + 5'(p * 2);
   endfunction

   function automatic int carrier_half(input longint clk_hz, input longint car_hz);
      return int'((clk_hz + car_hz) / (2 * car_hz));
   endfunction
endpackage

// File: rtl/pcio_sync.sv
module pcio_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] s1_q;
   logic [W-1:0] s2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= '1;
         s2_q <= '1;
      end else begin
         s1_q <= d;
         s2_q <= s1_q;
      end
   end

   assign q = s2_q;
endmodule

// File: rtl/pcio_carrier.sv
module pcio_carrier #(
   parameter int HALF = 1645
) (
   input  logic clk,
   input  logic rst_n,
   output logic carrier
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;
   logic          car_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         car_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         car_q <= ~car_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign carrier = car_q;
endmodule

// File: rtl/pcio_port_reg.sv
module pcio_port_reg #(
   parameter int         PW      = 8,
   parameter logic [7:0] DATA_A  = 8'h80,
   parameter logic [7:0] PU_A    = 8'hB2,
   parameter logic [4:0] BIT_BLK = 5'h10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    sfr_addr,
   input  logic          sfr_wr,
   input  logic [PW-1:0] sfr_wdata,
   input  logic          bit_wr,
   input  logic [7:0]    bit_addr,
   input  logic          bit_val,
   output logic [PW-1:0] latch,
   output logic [PW-1:0] pu_cfg
);
   localparam int IW = $clog2(PW);

   logic [PW-1:0] latch_q;
   logic [PW-1:0] pu_q;
   logic          byte_hit;
   logic          bit_hit;
   logic [IW-1:0] bit_idx;

   assign byte_hit = sfr_wr && (sfr_addr == DATA_A);
   assign bit_hit  = bit_wr && (bit_addr[7:3] == BIT_BLK);
   assign bit_idx  = bit_addr[IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '1;
      end else if (byte_hit) begin
         latch_q <= sfr_wdata;
      end else if (bit_hit) begin
         latch_q[bit_idx] <= bit_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pu_q <= '0;
      end else if (sfr_wr && (sfr_addr == PU_A)) begin
         pu_q <= sfr_wdata;
      end
   end

   assign latch  = latch_q;
   assign pu_cfg = pu_q;
endmodule

// File: rtl/pcio_pin_drive.sv
module pcio_pin_drive #(
   parameter int PW = 8
) (
   input  logic [PW-1:0] latch,
   input  logic [PW-1:0] pu_cfg,
   input  logic [PW-1:0] mod_sel,
   input  logic          carrier,
   output logic [PW-1:0] oe,
   output logic [PW-1:0] out,
   output logic [PW-1:0] pu
);
   for (genvar i = 0; i < PW; i++) begin : g_pin
      logic level;
      assign level = latch[i] ^ (mod_sel[i] & carrier);
      assign pu[i]  = ~pu_cfg[i];
      assign oe[i]  = pu_cfg[i] ? ~level : 1'b1;
      assign out[i] = pu_cfg[i] ? 1'b0   : level;
   end
endmodule

// File: rtl/port_carrier_io.sv
module port_carrier_io
   import pcio_pkg::*;
#(
   parameter longint CLK_HZ     = 125_000_000,
   parameter longint CARRIER_HZ = 38_000,
   parameter int     MOD_PORT   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           sfr_addr,
   input  logic                 sfr_wr,
   input  logic [7:0]           sfr_wdata,
   input  logic                 sfr_rd,
   input  logic                 rd_pin,
   output logic [7:0]           sfr_rdata,
   input  logic                 bit_wr,
   input  logic [7:0]           bit_addr,
   input  logic                 bit_val,
   input  logic                 mod_en,
   input  logic [NPORTS*PW-1:0] pin_in,
   output logic [NPORTS*PW-1:0] pin_oe,
   output logic [NPORTS*PW-1:0] pin_out,
   output logic [NPORTS*PW-1:0] pin_pu
);
   localparam int HALF = carrier_half(CLK_HZ, CARRIER_HZ);
   localparam int NPIN = NPORTS * PW;

   if (PW != 8) begin : g_bad_width
      $error("port width must be 8 to fit the byte bus");
   end
   if (CLK_HZ < 4 * CARRIER_HZ) begin : g_bad_clk
      $error("clock too slow for the carrier");
   end
   if (MOD_PORT < 0 || MOD_PORT >= NPORTS) begin : g_bad_mport
      $error("MOD_PORT out of range");
   end

   logic [NPIN-1:0] latch_vec;
   logic [NPIN-1:0] pu_vec;
   logic [NPIN-1:0] pin_sync;
   logic [PW-1:0]   mod_cfg_q;
   logic            carrier_q;

   pcio_sync #(.W(NPIN)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   pcio_carrier #(.HALF(HALF)) u_car (
      .clk     (clk),
      .rst_n   (rst_n),
      .carrier (carrier_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mod_cfg_q <= '0;
      end else if (sfr_wr && (sfr_addr == CFG_ADDR)) begin
         mod_cfg_q <= sfr_wdata;
      end
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [PW-1:0] sel;

      pcio_port_reg #(
         .PW      (PW),
         .DATA_A  (port_addr(p)),
         .PU_A    (pu_addr(p)),
         .BIT_BLK (port_bitblk(p))
      ) u_reg (
         .clk       (clk),
         .rst_n     (rst_n),
         .sfr_addr  (sfr_addr),
         .sfr_wr    (sfr_wr),
         .sfr_wdata (sfr_wdata),
         .bit_wr    (bit_wr),
         .bit_addr  (bit_addr),
         .bit_val   (bit_val),
         .latch     (latch_vec[p*PW +: PW]),
         .pu_cfg    (pu_vec[p*PW +: PW])
      );

      if (p == MOD_PORT) begin : g_mod
         assign sel = mod_en ? mod_cfg_q : '0;
      end else begin : g_plain
         assign sel = '0;
      end

      pcio_pin_drive #(.PW(PW)) u_drv (
         .latch   (latch_vec[p*PW +: PW]),
         .pu_cfg  (pu_vec[p*PW +: PW]),
         .mod_sel (sel),
         .carrier (carrier_q),
         .oe      (pin_oe[p*PW +: PW]),
         .out     (pin_out[p*PW +: PW]),
         .pu      (pin_pu[p*PW +: PW])
      );
   end

   always_comb begin
      sfr_rdata = '0;
      if (sfr_rd) begin
         if (sfr_addr == CFG_ADDR) sfr_rdata = mod_cfg_q;
         for (int p = 0; p < NPORTS; p++) begin
            if (sfr_addr == port_addr(p))
               sfr_rdata = rd_pin ? pin_sync[p*PW +: PW] : latch_vec[p*PW +: PW];
            if (sfr_addr == pu_addr(p))
               sfr_rdata = pu_vec[p*PW +: PW];
         end
      end
   end
endmodule

// File: rtl/pcio_checker.sv
module pcio_checker
   import pcio_pkg::*;
#(
   parameter int HALF     = 1645,
   parameter int MOD_PORT = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [7:0]           sfr_addr,
   input logic                 sfr_wr,
   input logic [7:0]           sfr_wdata,
   input logic                 sfr_rd,
   input logic [7:0]           sfr_rdata,
   input logic                 bit_wr,
   input logic [7:0]           bit_addr,
   input logic                 bit_val,
   input logic [NPORTS*PW-1:0] pin_oe,
   input logic [NPORTS*PW-1:0] pin_out,
   input logic [NPORTS*PW-1:0] pin_pu,
   input logic [NPORTS*PW-1:0] latch_vec,
   input logic                 carrier_q
);
   localparam int NPIN = NPORTS * PW;
   localparam logic [NPIN-1:0] MODMASK = {{(NPIN-PW){1'b0}}, {PW{1'b1}}} << (MOD_PORT*PW);

   logic        car_d;
   logic [31:0] gap_cnt;
   logic        bw_pend;
   logic [4:0]  bw_pos;
   logic        bw_val;
   logic        by_pend;
   logic [1:0]  by_port;
   logic [7:0]  by_val;
   logic        mapped;

   always_comb begin
      mapped = (sfr_addr == CFG_ADDR);
      for (int p = 0; p < NPORTS; p++)
         if (sfr_addr == port_addr(p) || sfr_addr == pu_addr(p)) mapped = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         car_d   <= 1'b0;
         gap_cnt <= '0;
         bw_pend <= 1'b0;
         bw_pos  <= '0;
         bw_val  <= 1'b0;
         by_pend <= 1'b0;
         by_port <= '0;
         by_val  <= '0;
      end else begin
         car_d   <= carrier_q;
         gap_cnt <= (carrier_q != car_d) ? 32'd1 : gap_cnt + 32'd1;
         bw_pend <= 1'b0;
         by_pend <= 1'b0;
         for (int p = 0; p < NPORTS; p++) begin
            if (sfr_wr && sfr_addr == port_addr(p)) begin
               by_pend <= 1'b1;
               by_port <= 2'(p);
               by_val  <= sfr_wdata;
            end else if (bit_wr && bit_addr[7:3] == port_bitblk(p)) begin
               bw_pend <= 1'b1;
               bw_pos  <= 5'(p*PW) + 5'(bit_addr[2:0]);
               bw_val  <= bit_val;
            end
         end
      end
   end

   a_r8_carrier_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (carrier_q != car_d) |-> (gap_cnt == 32'(HALF)));
   a_r8_carrier_bound: assert property (@(posedge clk) disable iff (!rst_n)
      gap_cnt <= 32'(HALF));
   a_r6_open_drain_low_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((~pin_pu) & pin_out) == '0);
   a_r6_pullup_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & ~pin_oe) == '0);
   a_r9_unmod_follow_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (((pin_out ^ latch_vec) & pin_pu & ~MODMASK) == '0) &&
      (((pin_oe ^ ~latch_vec) & ~pin_pu & ~MODMASK) == '0));
   a_r3_bit_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      bw_pend |-> (latch_vec[bw_pos] == bw_val));
   a_r2_byte_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      by_pend |-> (latch_vec[by_port*PW +: PW] == by_val));
   a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!sfr_rd || !mapped) |-> (sfr_rdata == 8'h00));
endmodule

bind port_carrier_io pcio_checker #(.HALF(HALF), .MOD_PORT(MOD_PORT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sfr_addr  (sfr_addr),
   .sfr_wr    (sfr_wr),
   .sfr_wdata (sfr_wdata),
   .sfr_rd    (sfr_rd),
   .sfr_rdata (sfr_rdata),
   .bit_wr    (bit_wr),
   .bit_addr  (bit_addr),
   .bit_val   (bit_val),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out),
   .pin_pu    (pin_pu),
   .latch_vec (latch_vec),
   .carrier_q (carrier_q)
);

// File: tb/tb_port_carrier_io.sv
`timescale 1ns/1ps
module tb_port_carrier_io;
   localparam longint CLK_HZ = 125_000_000;
   localparam longint CAR_HZ = 38_000;
   localparam int     HALF   = int'((CLK_HZ + CAR_HZ) / (2 * CAR_HZ));

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = '0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = '0;
   logic        sfr_rd = 1'b0;
   logic        rd_pin = 1'b0;
   logic [7:0]  sfr_rdata;
   logic        bit_wr = 1'b0;
   logic [7:0]  bit_addr = '0;
   logic        bit_val = 1'b0;
   logic        mod_en = 1'b0;
   logic [23:0] pin_in = '1;
   logic [23:0] pin_oe, pin_out, pin_pu;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] m_latch [3];
   logic [7:0] m_pu [3];

   always #4 clk = ~clk;

   port_carrier_io #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ), .MOD_PORT(1)) dut (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_rd(sfr_rd), .rd_pin(rd_pin),
      .sfr_rdata(sfr_rdata), .bit_wr(bit_wr), .bit_addr(bit_addr),
      .bit_val(bit_val), .mod_en(mod_en), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu));

   function automatic logic [7:0] daddr(input int p);
      return 8'h80 + 8'(p * 16);
   endfunction
   function automatic logic [7:0] paddr(input int p);
      return 8'hB2 + 8'(p);
   endfunction

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic bwr(input logic [7:0] a, input logic v);
      @(negedge clk);
      bit_addr = a; bit_val = v; bit_wr = 1'b1;
      @(negedge clk);
      bit_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic pin, output logic [7:0] d);
      sfr_addr = a; rd_pin = pin; sfr_rd = 1'b1;
      #1;
      d = sfr_rdata;
      sfr_rd = 1'b0; rd_pin = 1'b0;
   endtask

   task automatic check_drive(input string req);
      logic [23:0] eo, ev, ep;
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < 8; i++) begin
            ep[p*8+i] = ~m_pu[p][i];
            eo[p*8+i] = m_pu[p][i] ? ~m_latch[p][i] : 1'b1;
            ev[p*8+i] = m_pu[p][i] ? 1'b0 : m_latch[p][i];
         end
      end
      check({pin_oe, pin_out, pin_pu} == {eo, ev, ep}, req, {8'h0, pin_out}, {8'h0, ev});
   endtask

   initial begin
      #(8 * 190_000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [7:0] a;
      int lo, hi;
      void'($urandom(32'd20240611));
      for (int p = 0; p < 3; p++) begin m_latch[p] = 8'hFF; m_pu[p] = 8'h00; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      for (int p = 0; p < 3; p++) begin
         rd(daddr(p), 1'b0, d); check(d == 8'hFF, "R1 latch reset", d, 8'hFF);
         rd(paddr(p), 1'b0, d); check(d == 8'h00, "R1 pull-up reset", d, 8'h00);
      end
      rd(8'h9F, 1'b0, d); check(d == 8'h00, "R1 select reset", d, 8'h00);
      check_drive("R6 reset drive");

      // R2 random byte writes
      for (int k = 0; k < 30; k++) begin
         int p = int'($urandom_range(2, 0));
         logic [7:0] v = 8'($urandom);
         wr(daddr(p), v); m_latch[p] = v;
         rd(daddr(p), 1'b0, d); check(d == v, "R2 byte write readback", d, v);
      end

      // R3 random bit writes
      for (int k = 0; k < 40; k++) begin
         int p = int'($urandom_range(2, 0));
         int i = int'($urandom_range(7, 0));
         logic v = 1'($urandom);
         bwr({5'h10 + 5'(p * 2), 3'(i)}, v); m_latch[p][i] = v;
         rd(daddr(p), 1'b0, d); check(d == m_latch[p], "R3 bit write", d, m_latch[p]);
      end
      // R3 byte write wins over bit write on the same port
      @(negedge clk);
      sfr_addr = 8'h90; sfr_wdata = 8'h3C; sfr_wr = 1'b1;
      bit_addr = 8'h90; bit_val = 1'b1; bit_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0; bit_wr = 1'b0; m_latch[1] = 8'h3C;
      rd(8'h90, 1'b0, d); check(d == 8'h3C, "R3 byte priority", d, 8'h3C);

      // R5/R6 pull-up registers and drive
      for (int k = 0; k < 20; k++) begin
         int p = int'($urandom_range(2, 0));
         logic [7:0] v = 8'($urandom);
         wr(paddr(p), v); m_pu[p] = v;
         rd(paddr(p), 1'b0, d); check(d == v, "R5 pull-up readback", d, v);
         check_drive("R6 drive mode");
      end
      wr(8'h9F, 8'hA5);
      rd(8'h9F, 1'b0, d); check(d == 8'hA5, "R5 select readback", d, 8'hA5);
      check_drive("R9 select without mod_en");

      // R4 latch vs pin path with an external pull-down
      wr(8'h80, 8'hFF); m_latch[0] = 8'hFF;
      @(negedge clk); pin_in[3] = 1'b0;
      @(negedge clk);
      rd(8'h80, 1'b1, d); check(d == 8'hFF, "R4 one edge latency", d, 8'hFF);
      @(negedge clk);
      rd(8'h80, 1'b1, d); check(d == 8'hF7, "R4 pin read", d, 8'hF7);
      rd(8'h80, 1'b0, d); check(d == 8'hFF, "R4 latch read unaffected", d, 8'hFF);
      for (int k = 0; k < 10; k++) begin
         logic [23:0] v = 24'($urandom);
         @(negedge clk); pin_in = v;
         repeat (2) @(negedge clk);
         for (int p = 0; p < 3; p++) begin
            rd(daddr(p), 1'b1, d); check(d == v[p*8 +: 8], "R4 random pin read", d, v[p*8 +: 8]);
         end
      end
      pin_in = '1;

      // R10 unmapped accesses
      wr(8'h81, 8'h00); wr(8'hB5, 8'hFF); bwr(8'h88, 1'b0); bwr(8'hB0, 1'b0);
      rd(8'h81, 1'b0, d); check(d == 8'h00, "R10 unmapped read", d, 8'h00);
      for (int p = 0; p < 3; p++) begin
         rd(daddr(p), 1'b0, d); check(d == m_latch[p], "R10 latch untouched", d, m_latch[p]);
         rd(paddr(p), 1'b0, d); check(d == m_pu[p], "R10 pull-up untouched", d, m_pu[p]);
      end
      sfr_addr = 8'h80; #1;
      check(sfr_rdata == 8'h00, "R10 no strobe read", sfr_rdata, 8'h00);

      // R7/R8 modulation on port 1: pins 8 and 10 selected, 9 not
      for (int p = 0; p < 3; p++) begin wr(paddr(p), 8'h00); m_pu[p] = 8'h00; end
      wr(8'h9F, 8'h05);
      wr(8'h90, 8'h04); m_latch[1] = 8'h04;
      @(negedge clk); mod_en = 1'b1;
      while (pin_out[8] != 1'b0) @(negedge clk);
      while (pin_out[8] != 1'b1) @(negedge clk);
      hi = 0; lo = 0;
      while (pin_out[8] == 1'b1) begin
         hi++;
         check(pin_out[10] == 1'b0 && pin_out[9] == 1'b0, "R7 antiphase and unselected steady",
               {pin_out[10], pin_out[9]}, 0);
         @(negedge clk);
      end
      while (pin_out[8] == 1'b0) begin lo++; @(negedge clk); end
      check(hi == HALF, "R8 carrier high time", hi, HALF);
      check(lo == HALF, "R8 carrier low time", lo, HALF);
      rd(8'h90, 1'b0, d); check(d == 8'h04, "R7 latch read unmodulated", d, 8'h04);
      @(negedge clk); mod_en = 1'b0;
      #1;
      check(pin_out[15:8] == 8'h04, "R9 mod_en off", pin_out[15:8], 8'h04);
      repeat (HALF + 3) @(negedge clk);
      check(pin_out[15:8] == 8'h04, "R9 mod_en off after toggle", pin_out[15:8], 8'h04);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule